// File: doc/BRIEF.md
# Event Record Writer

This block turns one fault or configuration event into a fixed 256-bit record made of eight 32-bit words, and decides whether that record may go into a circular event ring in memory. Each field of the event has a fixed place in the record: the code, the stream and substream identifiers, the stall data, the access attributes, the class and two 64-bit addresses. Every bit that no field uses is written as zero.

The block keeps the ring's producer pointer. This pointer has one wrap bit above the slot index, and the consumer pointer comes in from outside in the same form. When an event arrives, three outcomes are possible. If the ring is enabled and has room, the record is offered for writing at the producer slot and the producer pointer advances. If the ring is disabled, the event is dropped with no other effect. If the ring is full, the event is dropped and a sticky overflow flag toggles, so that software can see a change since it last looked. The memory write itself and interrupt delivery belong to other blocks.

Top module: `evtq_record_writer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_req`, `prod_incr`, `prod_ptr` and `ovf_flag` become 0.
- R2: Record word 0 (record bits 31:0) carries the event code in bits 7:0, the substream-valid flag in bit 11 and the 20-bit substream ID in bits 31:12.
- R3: Record word 1 (record bits 63:32) carries the full 32-bit stream ID.
- R4: Record word 2 (record bits 95:64) carries the 16-bit stall tag in bits 15:0 and the stall flag in bit 31.
- R5: Record word 3 (record bits 127:96) carries the privileged flag in bit 1, the instruction flag in bit 2, the read flag in bit 3, the second-stage flag in bit 7 and the 2-bit class in bits 9:8.
- R6: The primary address fills word 4 (low half) and word 5 (high half). The secondary address fills word 6 (low half) and word 7 (high half). Word w occupies record bits 32w+31:32w.
- R7: Every record bit that no field uses is 0, even when every input bit is 1.
- R8: An event accepted at a clock edge (valid, ring enabled, ring not full) makes `wr_req` and `prod_incr` high for the following cycle. `wr_idx` then holds the low index bits of the producer pointer as they were before that edge, `rec_data` holds the packed record, and `prod_ptr` has advanced by one, modulo twice the depth.
- R9: An event that arrives while `q_en` is low raises neither `wr_req` nor `prod_incr` and changes neither `prod_ptr` nor `ovf_flag`.
- R10: An event that arrives while the ring is full raises no write, leaves `prod_ptr` unchanged and inverts `ovf_flag`.
- R11: `ovf_flag` keeps its value across accepted writes and idle cycles.
- R12: The ring is full only when the producer and consumer slot indices are equal and their wrap bits differ. Equal pointers mean the ring is empty, and the event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_en | input | 1 | Ring enable |
| cons_ptr | input | LOG2_DEPTH+1 | Consumer pointer: wrap bit over slot index |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_type | input | 8 | Event code |
| evt_sid | input | 32 | Stream ID |
| evt_ssid | input | 20 | Substream ID |
| evt_ssv | input | 1 | Substream ID valid |
| evt_stall | input | 1 | Stall flag |
| evt_stag | input | 16 | Stall tag |
| evt_pnu | input | 1 | Privileged access flag |
| evt_ind | input | 1 | Instruction fetch flag |
| evt_rnw | input | 1 | Read access flag |
| evt_s2 | input | 1 | Fault raised in second stage |
| evt_class | input | 2 | Access class |
| evt_addr | input | 64 | Primary address |
| evt_addr2 | input | 64 | Secondary address |
| rec_data | output | 256 | Packed record for the pending write |
| wr_req | output | 1 | Write the record to slot `wr_idx` |
| wr_idx | output | LOG2_DEPTH | Target ring slot |
| prod_incr | output | 1 | Producer pointer advanced this cycle |
| prod_ptr | output | LOG2_DEPTH+1 | Producer pointer: wrap bit over slot index |
| ovf_flag | output | 1 | Sticky, toggling overflow flag |

## Verification
The assertions assume that `cons_ptr` is a consistent ring pointer. It never gets ahead of `prod_ptr` and never trails it by more than the ring depth, so the occupancy, computed modulo twice the depth, stays between zero and the depth. They also assume that `cons_ptr` changes only between clock edges. The random stimulus meets this by keeping its own copy of the producer pointer and moving the consumer forward by a random amount no larger than the current occupancy. Directed sequences fill the ring exactly to full and overflow it several times, cross the wrap point, and send all-ones fields to check that unused bits stay zero.

// File: rtl/evtq_pkg.sv
// Package: shared record geometry and event code values for the event writer.
// Assumes a record of eight 32-bit words. Code values are listed for users of the record.
package evtq_pkg;
    localparam int WORD_W    = 32;
    localparam int REC_WORDS = 8;
    localparam int REC_W     = WORD_W * REC_WORDS;

    typedef enum logic [7:0] {
        EVC_UNTRANSLATED  = 8'h01,
        EVC_BAD_STREAM    = 8'h02,
        EVC_WALK_ABORT    = 8'h0B,
        EVC_XLATE_FAULT   = 8'h10,
        EVC_ADDR_RANGE    = 8'h11,
        EVC_ACCESS_FLAG   = 8'h12,
        EVC_PERMISSION    = 8'h13,
        EVC_TLB_CLASH     = 8'h20,
        EVC_CFG_CLASH     = 8'h21,
        EVC_PAGE_REQUEST  = 8'h24
    } evt_code_e;

    typedef struct packed {
        logic [7:0]  code;
        logic [31:0] sid;
        logic [19:0] ssid;
        logic        ssv;
        logic        stall;
        logic [15:0] stag;
        logic        pnu;
        logic        ind;
        logic        rnw;
        logic        s2;
        logic [1:0]  cls;
        logic [63:0] addr;
        logic [63:0] addr2;
    } evt_info_t;
endpackage

// File: rtl/evtq_rec_pack.sv
// Module: evtq_rec_pack
// Purely combinational. Places each event field at its fixed bit position in
// the eight-word record and drives every unused bit to zero.
// Assumes the event fields are stable while the result is captured.
module evtq_rec_pack
    import evtq_pkg::*;
(
    input  evt_info_t          info_i,
    output logic [REC_W-1:0]   rec_o
);
    logic [WORD_W-1:0] words [REC_WORDS];

    // Field placement: start from all zeros, then overlay the fields.
    always_comb begin
        for (int w = 0; w < REC_WORDS; w++) words[w] = '0;
        words[0][7:0]   = info_i.code;
        words[0][11]    = info_i.ssv;
        words[0][31:12] = info_i.ssid;
        words[1]        = info_i.sid;
        words[2][15:0]  = info_i.stag;
        words[2][31]    = info_i.stall;
        words[3][1]     = info_i.pnu;
        words[3][2]     = info_i.ind;
        words[3][3]     = info_i.rnw;
        words[3][7]     = info_i.s2;
        words[3][9:8]   = info_i.cls;
        words[4]        = info_i.addr[31:0];
        words[5]        = info_i.addr[63:32];
        words[6]        = info_i.addr2[31:0];
        words[7]        = info_i.addr2[63:32];
    end

    // Flatten: word w sits at bits 32w+31:32w.
    for (genvar w = 0; w < REC_WORDS; w++) begin : g_flat
        assign rec_o[w*WORD_W +: WORD_W] = words[w];
    end
endmodule

// File: rtl/evtq_prod_ctrl.sv
// Module: evtq_prod_ctrl
// Keeps the producer pointer and the toggling overflow flag, and decides
// whether an incoming event is accepted, dropped as disabled, or dropped as full.
// Assumes cons_ptr is a consistent ring pointer: never ahead of the producer
// and never more than the depth behind it.
module evtq_prod_ctrl #(
    parameter int LOG2_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  q_en,
    input  logic                  evt_valid,
    input  logic [LOG2_DEPTH:0]   cons_ptr,
    output logic                  accept_o,
    output logic [LOG2_DEPTH:0]   prod_ptr_o,
    output logic                  prod_incr_o,
    output logic                  ovf_o
);
    localparam int PTR_W = LOG2_DEPTH + 1;
    localparam logic [PTR_W-1:0] FULL_XOR = {1'b1, {LOG2_DEPTH{1'b0}}};

    logic full;
    logic drop_full;

    // Ring state: full when the indices match and the wrap bits differ.
    always_comb begin
        full      = (prod_ptr_o ^ cons_ptr) == FULL_XOR;
        accept_o  = evt_valid && q_en && !full;
        drop_full = evt_valid && q_en && full;
    end

    // Producer pointer, increment strobe and overflow toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_ptr_o  <= '0;
            prod_incr_o <= 1'b0;
            ovf_o       <= 1'b0;
        end else begin
            prod_incr_o <= accept_o;
            if (accept_o)  prod_ptr_o <= prod_ptr_o + 1'b1;
            if (drop_full) ovf_o      <= ~ovf_o;
        end
    end

    AST_FULL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        drop_full |=> (ovf_o != $past(ovf_o)) && $stable(prod_ptr_o) && !prod_incr_o); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_full |=> $stable(ovf_o)); // R11
    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !q_en) |=> !prod_incr_o && $stable(prod_ptr_o)); // R9
    AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        prod_incr_o |-> prod_ptr_o == $past(prod_ptr_o) + 1'b1); // R8
    AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && q_en && prod_ptr_o == cons_ptr) |=> prod_incr_o); // R12
endmodule

// File: rtl/evtq_record_writer.sv
// Module: evtq_record_writer (top)
// Packs an event into a 256-bit record and, when the ring has room, registers
// a one-cycle write request for the producer slot, together with the record.
// Assumes evt_valid is a single-cycle strobe and cons_ptr is a consistent ring pointer.
module evtq_record_writer #(
    parameter int LOG2_DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_en,
    input  logic [LOG2_DEPTH:0]  cons_ptr,
    input  logic                 evt_valid,
    input  logic [7:0]           evt_type,
    input  logic [31:0]          evt_sid,
    input  logic [19:0]          evt_ssid,
    input  logic                 evt_ssv,
    input  logic                 evt_stall,
    input  logic [15:0]          evt_stag,
    input  logic                 evt_pnu,
    input  logic                 evt_ind,
    input  logic                 evt_rnw,
    input  logic                 evt_s2,
    input  logic [1:0]           evt_class,
    input  logic [63:0]          evt_addr,
    input  logic [63:0]          evt_addr2,
    output logic [255:0]         rec_data,
    output logic                 wr_req,
    output logic [LOG2_DEPTH-1:0] wr_idx,
    output logic                 prod_incr,
    output logic [LOG2_DEPTH:0]  prod_ptr,
    output logic                 ovf_flag
);
    import evtq_pkg::*;

    evt_info_t        info;
    logic [REC_W-1:0] rec_next;
    logic             accept;

    // Gather the event fields into one struct.
    always_comb begin
        info.code  = evt_type;
        info.sid   = evt_sid;
        info.ssid  = evt_ssid;
        info.ssv   = evt_ssv;
        info.stall = evt_stall;
        info.stag  = evt_stag;
        info.pnu   = evt_pnu;
        info.ind   = evt_ind;
        info.rnw   = evt_rnw;
        info.s2    = evt_s2;
        info.cls   = evt_class;
        info.addr  = evt_addr;
        info.addr2 = evt_addr2;
    end

    evtq_rec_pack u_pack (
        .info_i (info),
        .rec_o  (rec_next)
    );

    evtq_prod_ctrl #(.LOG2_DEPTH(LOG2_DEPTH)) u_prod (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_en        (q_en),
        .evt_valid   (evt_valid),
        .cons_ptr    (cons_ptr),
        .accept_o    (accept),
        .prod_ptr_o  (prod_ptr),
        .prod_incr_o (prod_incr),
        .ovf_o       (ovf_flag)
    );

    // Write request stage: capture the record and target slot on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req   <= 1'b0;
            wr_idx   <= '0;
            rec_data <= '0;
        end else begin
            wr_req <= accept;
            if (accept) begin
                wr_idx   <= prod_ptr[LOG2_DEPTH-1:0];
                rec_data <= rec_next;
            end
        end
    end

    AST_WR_WITH_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req == prod_incr); // R8
    AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_idx == $past(prod_ptr[LOG2_DEPTH-1:0])); // R8
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (rec_data[10:8] == 3'b0) && (rec_data[94:80] == 15'b0) &&
                   !rec_data[96] && (rec_data[102:100] == 3'b0) &&
                   (rec_data[127:106] == 22'b0)); // R7
    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !q_en) |=> !wr_req && $stable(ovf_flag)); // R9
endmodule

// File: tb/evtq_record_writer_tb.sv
module evtq_record_writer_tb;
    localparam int L     = 3;
    localparam int DEPTH = 1 << L;
    localparam int PTR_W = L + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic q_en;
    logic [PTR_W-1:0] cons_ptr;
    logic evt_valid;
    logic [7:0]  evt_type;
    logic [31:0] evt_sid;
    logic [19:0] evt_ssid;
    logic evt_ssv, evt_stall, evt_pnu, evt_ind, evt_rnw, evt_s2;
    logic [15:0] evt_stag;
    logic [1:0]  evt_class;
    logic [63:0] evt_addr, evt_addr2;
    logic [255:0] rec_data;
    logic wr_req, prod_incr, ovf_flag;
    logic [L-1:0] wr_idx;
    logic [PTR_W-1:0] prod_ptr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [PTR_W-1:0] mprod = '0;
    logic [PTR_W-1:0] mcons = '0;
    logic movf = 1'b0;

    always #4 clk = ~clk;

    evtq_record_writer #(.LOG2_DEPTH(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .cons_ptr(cons_ptr),
        .evt_valid(evt_valid), .evt_type(evt_type), .evt_sid(evt_sid),
        .evt_ssid(evt_ssid), .evt_ssv(evt_ssv), .evt_stall(evt_stall),
        .evt_stag(evt_stag), .evt_pnu(evt_pnu), .evt_ind(evt_ind),
        .evt_rnw(evt_rnw), .evt_s2(evt_s2), .evt_class(evt_class),
        .evt_addr(evt_addr), .evt_addr2(evt_addr2), .rec_data(rec_data),
        .wr_req(wr_req), .wr_idx(wr_idx), .prod_incr(prod_incr),
        .prod_ptr(prod_ptr), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected record, built field by field from R2 to R7.
    function automatic logic [255:0] exp_rec();
        logic [255:0] r = '0;
        r[7:0]    = evt_type;   r[11]     = evt_ssv;   r[31:12] = evt_ssid;
        r[63:32]  = evt_sid;
        r[79:64]  = evt_stag;   r[95]     = evt_stall;
        r[97]     = evt_pnu;    r[98]     = evt_ind;   r[99]    = evt_rnw;
        r[103]    = evt_s2;     r[105:104] = evt_class;
        r[191:128] = evt_addr;  r[255:192] = evt_addr2;
        return r;
    endfunction

    task automatic rand_fields();
        evt_type  = 8'($urandom);  evt_sid   = $urandom;
        evt_ssid  = 20'($urandom); evt_ssv   = 1'($urandom);
        evt_stall = 1'($urandom);  evt_stag  = 16'($urandom);
        evt_pnu   = 1'($urandom);  evt_ind   = 1'($urandom);
        evt_rnw   = 1'($urandom);  evt_s2    = 1'($urandom);
        evt_class = 2'($urandom);
        evt_addr  = {$urandom, $urandom}; evt_addr2 = {$urandom, $urandom};
    endtask

    // One event cycle: drive after a falling edge, check after the next one.
    task automatic step(input bit v, input bit en);
        bit full, acc;
        logic [PTR_W-1:0] pprev;
        logic [255:0] er;
        evt_valid = v; q_en = en; cons_ptr = mcons;
        full  = ((mprod ^ mcons) == PTR_W'(DEPTH));   // R12
        acc   = v && en && !full;
        pprev = mprod;
        er    = exp_rec();
        @(negedge clk);
        if (acc) mprod = mprod + 1'b1;
        if (v && en && full) movf = ~movf;
        check("R8 R9 R10 wr_req", 256'(wr_req), 256'(acc));
        check("R8 prod_incr", 256'(prod_incr), 256'(acc));
        if (acc) begin
            check("R8 wr_idx", 256'(wr_idx), 256'(pprev[L-1:0]));
            check("R2 R3 R4 R5 R6 R7 rec_data", rec_data, er);
        end
        check("R8 R9 R10 R12 prod_ptr", 256'(prod_ptr), 256'(mprod));
        check("R10 R11 ovf_flag", 256'(ovf_flag), 256'(movf));
        evt_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; q_en = 1'b0; cons_ptr = '0; evt_valid = 1'b0;
        rand_fields();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 wr_req", 256'(wr_req), 256'(0));
        check("R1 prod_incr", 256'(prod_incr), 256'(0));
        check("R1 prod_ptr", 256'(prod_ptr), 256'(0));
        check("R1 ovf_flag", 256'(ovf_flag), 256'(0));
        rst_n = 1'b1;

        // R7: all-ones fields leave unused bits zero
        {evt_type, evt_sid, evt_ssid, evt_ssv, evt_stall, evt_stag} = '1;
        {evt_pnu, evt_ind, evt_rnw, evt_s2, evt_class, evt_addr, evt_addr2} = '1;
        step(1, 1);
        check("R7 word0", 256'(rec_data[31:0]), 256'(32'hFFFF_F8FF));
        check("R7 word2", 256'(rec_data[95:64]), 256'(32'h8000_FFFF));
        check("R7 word3", 256'(rec_data[127:96]), 256'(32'h0000_038E));

        // R2 R3 R4 R5 R6: a distinct random pattern
        rand_fields(); step(1, 1);

        // R9: disabled ring drops the event
        rand_fields(); step(1, 0);
        rand_fields(); step(1, 0);

        // Fill to exactly full (consumer held at 0), crossing into the wrap half
        while (mprod != PTR_W'(DEPTH)) begin rand_fields(); step(1, 1); end
        // R10: overflow toggles on each full drop
        rand_fields(); step(1, 1);
        check("R10 ovf set", 256'(ovf_flag), 256'(1));
        rand_fields(); step(1, 1);
        check("R10 ovf toggled back", 256'(ovf_flag), 256'(0));
        rand_fields(); step(1, 1);
        // R11: room frees, accepted writes keep the flag
        mcons = mcons + 1'b1;
        rand_fields(); step(1, 1);
        check("R11 ovf kept", 256'(ovf_flag), 256'(1));
        step(0, 1);
        // R12: equal pointers with both wrap bits set means empty
        mcons = mprod;
        rand_fields(); step(1, 1);

        // Random traffic with a consistent consumer
        for (int i = 0; i < 600; i++) begin
            logic [PTR_W-1:0] occ;
            occ = mprod - mcons;
            if ($urandom_range(0, 3) == 0)
                mcons = mcons + PTR_W'($urandom_range(0, int'(occ)));
            rand_fields();
            if ($urandom_range(0, 9) == 0) evt_type = 8'h24;
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) != 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule